// File: doc/BRIEF.md
# Bus Turnaround Gap Controller

This block sits in front of an external static memory sequencer. It decides how many idle kernel clock cycles must pass between the end of one transaction and the start of the next. Each transaction is described by four attributes: whether it is synchronous, whether it is a write, whether it uses a multiplexed or mode-D address phase, and which bank it targets. Each bank also has a programmed turnaround value of 0 to 15 cycles.

The block records the attributes of the transaction it last launched. When that transaction reports done, the block starts counting idle cycles. A pending request is presented with its attributes. The block then derives the required gap from the previous and the pending transaction. Fixed rules can replace the programmed count or add a minimum to it. The block holds `gapReady` low until that many idle cycles have passed. A request is launched on the cycle where `reqValid` and `gapReady` are both high.

Top module: `turn_gap_top`

## Requirements
- R1: After reset, and until the first launch, `gapReady` is high and `gapCycles` is 0, so the first transaction starts with no gap.
- R2: From the cycle after a launch until `txnDone` is sampled, `gapReady` and `txnGo` stay low.
- R3: The programmed value of the previous transaction's bank applies in two cases: after an asynchronous write that is not muxed, and after any asynchronous muxed read or muxed write. A programmed value of 0 gives no gap.
- R4: An asynchronous non-muxed write followed by an asynchronous write to the same bank needs a gap of 0, whatever the programmed value.
- R5: An asynchronous non-muxed read needs a gap of 1 in two cases: before an asynchronous read to the same bank, and before a write of either kind to any bank.
- R6: A synchronous write needs a gap of 2 in two cases: before a synchronous write to the same bank, and before an asynchronous read or write to any bank.
- R7: A synchronous write needs a gap of 3 in two cases: before a synchronous write to a different bank, and before a synchronous read to any bank.
- R8: With a required gap of G, `gapReady` stays low for exactly G cycles after the cycle in which `txnDone` was sampled. It is high in the next cycle, and `gapCycles` shows G throughout.
- R9: Pairs that match no rule need a gap of 0. Two examples: a synchronous read followed by anything, and an asynchronous non-muxed read followed by a read to another bank.
- R10: `txnGo` is high only when `reqValid` and `gapReady` are both high. A request held during a gap is not launched early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bankTurnFlat | input | NUM_BANKS*TURN_W | Programmed turnaround per bank; bank k occupies bits [k*TURN_W +: TURN_W] |
| reqValid | input | 1 | A transaction is pending |
| reqSync | input | 1 | Pending transaction is synchronous (1) or asynchronous (0) |
| reqWrite | input | 1 | Pending transaction is a write (1) or a read (0) |
| reqMuxed | input | 1 | Pending transaction uses muxed or mode-D addressing |
| reqBank | input | BANK_W | Target bank of the pending transaction |
| txnDone | input | 1 | One-cycle pulse: the launched transaction has finished |
| gapReady | output | 1 | The pending transaction may start |
| txnGo | output | 1 | The pending transaction is launched this cycle |
| gapCycles | output | TURN_W | Required gap between the previous and the pending transaction |

## Verification
The embedded assertions check several properties on every cycle:
- Readiness drops after every launch.
- No gap is required before the first launch.
- The saturated idle counter holds its value.
- Same-bank asynchronous write pairs never get a gap.
- Only a programmed value can push the gap above the fixed maximum of 3.
- The remembered attributes change only at a launch.

The bench's directed pairs are needed for the rest:
- the exact fixed gap for each class of transaction pair;
- that the programmed count is taken from the previous transaction's bank rather than the new one;
- that the number of idle cycles before readiness equals the reported gap.

// File: rtl/turn_gap_pkg.sv
package turn_gap_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } gapState_e;

  typedef struct packed {
    logic captPrev;
    logic clrElapsed;
    logic incElapsed;
  } gapStrobe_t;

endpackage

// File: rtl/turn_gap_rules.sv
module turn_gap_rules #(
  parameter int NUM_BANKS = 4,
  parameter int TURN_W    = 4,
  parameter int BANK_W    = 2
) (
  input  logic                        hasPrev,
  input  logic                        prevSync,
  input  logic                        prevWrite,
  input  logic                        prevMuxed,
  input  logic [BANK_W-1:0]           prevBank,
  input  logic                        nextSync,
  input  logic                        nextWrite,
  input  logic [BANK_W-1:0]           nextBank,
  input  logic [NUM_BANKS*TURN_W-1:0] bankTurnFlat,
  output logic                        progApplies,
  output logic [TURN_W-1:0]           gapCycles
);

  localparam logic [TURN_W-1:0] GAP_ZERO  = '0;
  localparam logic [TURN_W-1:0] GAP_ONE   = TURN_W'(1);
  localparam logic [TURN_W-1:0] GAP_TWO   = TURN_W'(2);
  localparam logic [TURN_W-1:0] GAP_THREE = TURN_W'(3);

  logic [TURN_W-1:0] turnArr [NUM_BANKS];

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_turn
      assign turnArr[gb] = bankTurnFlat[gb*TURN_W +: TURN_W];
    end
  endgenerate

  logic              sameBank;
  logic              pAsyncWrPlain;
  logic              pAsyncRdPlain;
  logic              pAsyncMuxed;
  logic              pSyncWr;
  logic              skipProg;
  logic [TURN_W-1:0] fixedGap;
  logic [TURN_W-1:0] progGap;

  assign sameBank      = (prevBank == nextBank);
  assign pAsyncWrPlain = !prevSync && prevWrite && !prevMuxed;
  assign pAsyncRdPlain = !prevSync && !prevWrite && !prevMuxed;
  assign pAsyncMuxed   = !prevSync && prevMuxed;
  assign pSyncWr       = prevSync && prevWrite;
  assign progGap       = turnArr[prevBank];

  // same-bank plain async writes run back to back
  assign skipProg    = pAsyncWrPlain && !nextSync && nextWrite && sameBank;
  assign progApplies = hasPrev && (pAsyncWrPlain || pAsyncMuxed) && !skipProg;

  always_comb begin
    fixedGap = GAP_ZERO;
    if (hasPrev) begin
      if (pAsyncRdPlain) begin
        if (nextWrite) fixedGap = GAP_ONE;
        else if (!nextSync && sameBank) fixedGap = GAP_ONE;
      end else if (pSyncWr) begin
        if (!nextSync) fixedGap = GAP_TWO;
        else if (!nextWrite) fixedGap = GAP_THREE;
        else if (sameBank) fixedGap = GAP_TWO;
        else fixedGap = GAP_THREE;
      end
    end
  end

  always_comb begin
    gapCycles = fixedGap;
    if (progApplies && (progGap > fixedGap)) gapCycles = progGap;
  end

endmodule

// File: rtl/turn_gap_datapath.sv
module turn_gap_datapath
  import turn_gap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TURN_W    = 4,
  parameter int BANK_W    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  gapStrobe_t                  stb,
  input  logic [NUM_BANKS*TURN_W-1:0] bankTurnFlat,
  input  logic                        reqSync,
  input  logic                        reqWrite,
  input  logic                        reqMuxed,
  input  logic [BANK_W-1:0]           reqBank,
  output logic                        gapMet,
  output logic                        hasPrev,
  output logic [TURN_W-1:0]           gapCycles
);

  localparam logic [TURN_W-1:0] ELAPSED_MAX = '1;

  logic              prevSync;
  logic              prevWrite;
  logic              prevMuxed;
  logic [BANK_W-1:0] prevBank;
  logic [TURN_W-1:0] elapsed;
  logic              progApplies;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hasPrev   <= 1'b0;
      prevSync  <= 1'b0;
      prevWrite <= 1'b0;
      prevMuxed <= 1'b0;
      prevBank  <= '0;
    end else if (stb.captPrev) begin
      hasPrev   <= 1'b1;
      prevSync  <= reqSync;
      prevWrite <= reqWrite;
      prevMuxed <= reqMuxed;
      prevBank  <= reqBank;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
    end else if (stb.clrElapsed) begin
      elapsed <= '0;
    end else if (stb.incElapsed && (elapsed != ELAPSED_MAX)) begin
      elapsed <= elapsed + TURN_W'(1);
    end
  end

  turn_gap_rules #(
    .NUM_BANKS(NUM_BANKS),
    .TURN_W   (TURN_W),
    .BANK_W   (BANK_W)
  ) u_rules (
    .hasPrev     (hasPrev),
    .prevSync    (prevSync),
    .prevWrite   (prevWrite),
    .prevMuxed   (prevMuxed),
    .prevBank    (prevBank),
    .nextSync    (reqSync),
    .nextWrite   (reqWrite),
    .nextBank    (reqBank),
    .bankTurnFlat(bankTurnFlat),
    .progApplies (progApplies),
    .gapCycles   (gapCycles)
  );

  assign gapMet = (elapsed >= gapCycles);

  AST_NO_GAP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    !hasPrev |-> (gapCycles == '0)); // R1

  AST_ELAPSED_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (elapsed == ELAPSED_MAX) && !stb.clrElapsed |=> (elapsed == ELAPSED_MAX)); // R8

  AST_FIXED_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !progApplies |-> (gapCycles <= TURN_W'(3))); // R7

  AST_WR_PAIR_FREE: assert property (@(posedge clk) disable iff (!rstN)
    hasPrev && !prevSync && prevWrite && !prevMuxed && !reqSync && reqWrite
      && (reqBank == prevBank) |-> (gapCycles == '0)); // R4

  AST_PREV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.captPrev |=> $stable(prevBank) && $stable(prevWrite)); // R3

endmodule

// File: rtl/turn_gap_ctrl.sv
module turn_gap_ctrl
  import turn_gap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       txnDone,
  input  logic       gapMet,
  output gapStrobe_t stb,
  output logic       gapReady,
  output logic       txnGo
);

  gapState_e state;
  gapState_e stateNxt;

  assign gapReady = (state == ST_FREE) || ((state == ST_GAP) && gapMet);
  assign txnGo    = reqValid && gapReady;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_FREE: if (txnGo) stateNxt = ST_BUSY;
      ST_BUSY: if (txnDone) stateNxt = ST_GAP;
      ST_GAP:  if (txnGo) stateNxt = ST_BUSY;
      default: stateNxt = ST_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FREE;
    else       state <= stateNxt;
  end

  always_comb begin
    stb            = '0;
    stb.captPrev   = txnGo;
    stb.clrElapsed = (state == ST_BUSY) && txnDone;
    stb.incElapsed = (state == ST_GAP);
  end

  AST_LAUNCH_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    txnGo |=> !gapReady); // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) && !txnDone |=> !txnGo); // R2

  AST_GO_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    txnGo |-> reqValid); // R10

endmodule

// File: rtl/turn_gap_top.sv
module turn_gap_top
  import turn_gap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TURN_W    = 4,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_BANKS*TURN_W-1:0] bankTurnFlat,
  input  logic                        reqValid,
  input  logic                        reqSync,
  input  logic                        reqWrite,
  input  logic                        reqMuxed,
  input  logic [BANK_W-1:0]           reqBank,
  input  logic                        txnDone,
  output logic                        gapReady,
  output logic                        txnGo,
  output logic [TURN_W-1:0]           gapCycles
);

  gapStrobe_t stb;
  logic       gapMet;
  logic       hasPrev;

  turn_gap_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .txnDone (txnDone),
    .gapMet  (gapMet),
    .stb     (stb),
    .gapReady(gapReady),
    .txnGo   (txnGo)
  );

  turn_gap_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .TURN_W   (TURN_W),
    .BANK_W   (BANK_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .bankTurnFlat(bankTurnFlat),
    .reqSync     (reqSync),
    .reqWrite    (reqWrite),
    .reqMuxed    (reqMuxed),
    .reqBank     (reqBank),
    .gapMet      (gapMet),
    .hasPrev     (hasPrev),
    .gapCycles   (gapCycles)
  );

  AST_FIRST_READY: assert property (@(posedge clk) disable iff (!rstN)
    !hasPrev |-> gapReady); // R1

endmodule

// File: tb/turn_gap_top_tb.sv
module turn_gap_top_tb;

  localparam int NUM_BANKS = 4;
  localparam int TURN_W    = 4;
  localparam int BANK_W    = 2;

  logic                        clk = 1'b0;
  logic                        rstN = 1'b0;
  logic [NUM_BANKS*TURN_W-1:0] bankTurnFlat;
  logic                        reqValid = 1'b0;
  logic                        reqSync = 1'b0;
  logic                        reqWrite = 1'b0;
  logic                        reqMuxed = 1'b0;
  logic [BANK_W-1:0]           reqBank = '0;
  logic                        txnDone = 1'b0;
  logic                        gapReady;
  logic                        txnGo;
  logic [TURN_W-1:0]           gapCycles;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  // bank0=5, bank1=9, bank2=0, bank3=15
  assign bankTurnFlat = {4'd15, 4'd0, 4'd9, 4'd5};

  turn_gap_top #(.NUM_BANKS(NUM_BANKS), .TURN_W(TURN_W), .BANK_W(BANK_W)) u_dut (
    .clk(clk), .rstN(rstN), .bankTurnFlat(bankTurnFlat),
    .reqValid(reqValid), .reqSync(reqSync), .reqWrite(reqWrite),
    .reqMuxed(reqMuxed), .reqBank(reqBank), .txnDone(txnDone),
    .gapReady(gapReady), .txnGo(txnGo), .gapCycles(gapCycles)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Present one transaction, measure the idle cycles before it may start,
  // launch it, keep it busy, then report done. Starts and ends at a negedge.
  task automatic doTxn(input logic s, input logic w, input logic m, input int b,
                       input int expGap, input logic measure, input string tag);
    int lowCnt;
    reqValid = 1'b1; reqSync = s; reqWrite = w; reqMuxed = m; reqBank = BANK_W'(b);
    #1;
    if (measure) check(gapCycles == TURN_W'(expGap), {tag, " gapCycles"}, gapCycles, expGap);
    lowCnt = 0;
    while (!gapReady && lowCnt < 40) begin
      if (measure) check(txnGo == 1'b0, "R10 held request launched early", txnGo, 0);
      if (measure) check(gapCycles == TURN_W'(expGap), "R8 gap stable", gapCycles, expGap);
      lowCnt++;
      @(negedge clk); #1;
    end
    if (measure) check(lowCnt == expGap, {tag, " idle cycles (R8)"}, lowCnt, expGap);
    check(txnGo == 1'b1, "R10 launch when ready", txnGo, 1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      check(gapReady == 1'b0, "R2 ready while busy", gapReady, 0);
      reqValid = 1'b1;
      #1;
      check(txnGo == 1'b0, "R2 go while busy", txnGo, 0);
      reqValid = 1'b0;
      @(negedge clk);
    end
    txnDone = 1'b1;
    @(posedge clk);
    @(negedge clk);
    txnDone = 1'b0;
  endtask

  task automatic pairTest(input logic s0, input logic w0, input logic m0, input int b0,
                          input logic s1, input logic w1, input logic m1, input int b1,
                          input int expGap, input string tag);
    doTxn(s0, w0, m0, b0, 0, 1'b0, tag);
    doTxn(s1, w1, m1, b1, expGap, 1'b1, tag);
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    check(gapReady == 1'b1, "R1 ready after reset", gapReady, 1);
    reqValid = 1'b1; reqSync = 1'b1; reqWrite = 1'b1; reqBank = 2'd3;
    #1;
    check(gapCycles == '0, "R1 gap after reset", gapCycles, 0);
    reqValid = 1'b0;
    @(negedge clk);
    doTxn(1'b1, 1'b1, 1'b0, 3, 0, 1'b1, "R1 first transaction");
  endtask

  task automatic testProgrammed();
    pairTest(0, 1, 0, 0,  0, 0, 0, 0,  5,  "R3 async wr b0 -> rd b0");
    pairTest(0, 1, 0, 1,  0, 1, 0, 2,  9,  "R3 async wr b1 -> wr b2");
    pairTest(0, 0, 1, 1,  1, 0, 0, 2,  9,  "R3 muxed rd b1 -> sync rd b2");
    pairTest(0, 1, 0, 2,  1, 0, 0, 0,  0,  "R3 programmed zero");
  endtask

  task automatic testSameBankWrites();
    pairTest(0, 1, 0, 0,  0, 1, 0, 0,  0,  "R4 async wr pair same bank");
    pairTest(0, 1, 1, 3,  0, 1, 1, 3,  15, "R4 muxed wr pair keeps programmed");
  endtask

  task automatic testAsyncRead();
    pairTest(0, 0, 0, 2,  0, 0, 0, 2,  1,  "R5 async rd pair same bank");
    pairTest(0, 0, 0, 0,  1, 1, 0, 3,  1,  "R5 async rd -> sync wr");
  endtask

  task automatic testSyncWrite();
    pairTest(1, 1, 0, 1,  1, 1, 0, 1,  2,  "R6 sync wr pair same bank");
    pairTest(1, 1, 0, 0,  0, 0, 0, 2,  2,  "R6 sync wr -> async rd");
    pairTest(1, 1, 0, 1,  1, 1, 0, 2,  3,  "R7 sync wr pair other bank");
    pairTest(1, 1, 0, 0,  1, 0, 0, 0,  3,  "R7 sync wr -> sync rd");
  endtask

  task automatic testNoRule();
    pairTest(1, 0, 0, 0,  0, 1, 0, 1,  0,  "R9 sync rd -> async wr");
    pairTest(0, 0, 0, 1,  0, 0, 0, 2,  0,  "R9 async rd -> rd other bank");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testProgrammed();
    testSameBankWrites();
    testAsyncRead();
    testSyncWrite();
    testNoRule();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule